// File: doc/BRIEF.md
# Delay-Line Voltage Quantizer Back End

This block is the digital half of a voltage quantizer that measures time instead of voltage. The analog delay line is supplied from the sensed voltage, so a pulse travels further along it when the voltage is higher. When the block accepts a period strobe, it fires a test pulse into the line. It lets the pulse run for a fixed number of clock cycles, then captures every tap in the same clock edge. The number of taps reached becomes a small signed error, centred on zero. After each conversion the line is held cleared until the next period begins.

Self-calibration is optional. In a reference period the line first converts a stable reference voltage, and the resulting code is stored. After a short clear gap, the line converts the real input. The stored reference code is subtracted from the input code and the difference is clipped to the error range. A programmable divider sets how often a reference period occurs. Every other period performs only the input conversion and reuses the stored reference code.

Top module: `dlq_backend`

## Requirements
- R1: After reset, line_clear is 1, and pulse_launch, tap_sample, ref_select and err_valid are all 0.
- R2: A period_start strobe is accepted only while the line is idle between periods. pulse_launch rises in the cycle after the accepted strobe and stays high for CONV_CYC cycles. A strobe seen during a conversion or during the gap is ignored and causes no extra conversion.
- R3: tap_sample is high in the last cycle of each launch window. The taps are captured at the clock edge that ends that cycle.
- R4: Outside the launch windows line_clear is high. After the last input conversion of a period, line_clear stays high and pulse_launch stays low until the next accepted strobe.
- R5: taps[0] is the cell nearest the launch point, and a valid pattern fills upward from bit 0. The code is the number of set taps minus NTAPS/2. With eight taps: 8'b00001111 gives 0, 8'hFF gives +4, 8'h00 gives -4 and 8'h3F gives +2.
- R6: A pattern that is not a thermometer (a bubble) is encoded by its count of ones alone. For example, 8'b10100101 gives 0.
- R7: err_valid is high for exactly one cycle, two cycles after the tap_sample cycle of an input conversion. That is CONV_CYC+1 cycles after the strobe edge in a single-conversion period. No err_valid follows a reference conversion.
- R8: With cal_en low, each period runs one conversion with ref_select low, and err_out equals the raw input code.
- R9: In a reference period, the first conversion runs with ref_select high. It is followed by GAP_CYC cycles with line_clear high and ref_select low, and then the input conversion. The stored reference code is replaced, and err_out is the input code minus the reference code, clipped to -NTAPS/2..+NTAPS/2. err_valid then comes 2*CONV_CYC+GAP_CYC+1 cycles after the strobe edge.
- R10: With cal_en high, a reference period occurs once every cal_div+1 accepted periods, and the first accepted period after cal_en is raised is a reference period. Every other period converts only the input and subtracts the stored reference code, even if the reference voltage has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_start | input | 1 | One-cycle strobe at the start of each switching period |
| cal_en | input | 1 | Enables reference conversion and subtraction |
| cal_div | input | CALW | Reference repeat interval minus one, counted in periods |
| taps | input | NTAPS | Live tap outputs of the delay line, bit 0 nearest the launch point |
| pulse_launch | output | 1 | Test pulse driven into the line during a conversion window |
| line_clear | output | 1 | Holds every delay cell cleared |
| tap_sample | output | 1 | High in the cycle whose ending edge captures the taps |
| ref_select | output | 1 | Selects the reference voltage as the line supply |
| err_out | output | $clog2(NTAPS/2+1)+1 | Signed quantized error |
| err_valid | output | 1 | One-cycle strobe marking a new err_out |

## Verification
The hardest situation to reach from the ports is a reference code that is stale but still reused. To show it, the reference period must be followed by periods in which the reference voltage has moved while the stored code stays in force. The stimulus therefore changes the modelled reference pattern every period while the divider is above zero. It then compares err_out against the code stored at the last reference period, not against the current reference pattern. Clipping is reached by pairing an all-ones reference with an all-zeros input, and the reverse. Ignored strobes are placed inside both the launch window and the calibration gap.

// File: rtl/dlq_pkg.sv
// Shared types for the delay-line quantizer back end.
package dlq_pkg;

    // Phase of the conversion sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_GAP    = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dlq_sequencer.sv
// Conversion sequencer.
// Accepts a period strobe while idle. Runs one input conversion, or a
// reference conversion followed by a clear gap and an input conversion.
// Drives the launch, clear, sample and supply-select controls.
// Assumes CONV_CYC >= 1, GAP_CYC >= 1, and a period long enough for
// the whole sequence to finish before the next strobe.
module dlq_sequencer
    import dlq_pkg::*;
#(
    parameter int CONV_CYC = 6,
    parameter int GAP_CYC  = 3,
    parameter int CALW     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            period_start,
    input  logic            cal_en,
    input  logic [CALW-1:0] cal_div,
    output logic            pulse_launch,
    output logic            line_clear,
    output logic            tap_sample,
    output logic            ref_select,
    output logic            sub_mode
);

    localparam int MAXC = (CONV_CYC > GAP_CYC) ? CONV_CYC : GAP_CYC;
    localparam int CNTW = $clog2(MAXC + 1);
    localparam logic [CNTW-1:0] CONV_LAST = CNTW'(CONV_CYC - 1);
    localparam logic [CNTW-1:0] GAP_LAST  = CNTW'(GAP_CYC - 1);
    localparam logic [CALW-1:0] CAL_ONE   = {{(CALW-1){1'b0}}, 1'b1};

    seq_state_e      st;
    logic [CNTW-1:0] cnt;
    logic            ref_phase;
    logic            sub_q;
    logic [CALW-1:0] cal_cnt;
    logic            accept;

    // Strobe acceptance: only honoured between periods.
    assign accept = (st == SEQ_IDLE) && period_start;

    // Phase and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SEQ_IDLE;
            cnt       <= '0;
            ref_phase <= 1'b0;
            sub_q     <= 1'b0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (accept) begin
                        st        <= SEQ_LAUNCH;
                        cnt       <= '0;
                        ref_phase <= cal_en && (cal_cnt == '0);
                        sub_q     <= cal_en;
                    end
                end
                SEQ_LAUNCH: begin
                    if (cnt == CONV_LAST) begin
                        cnt <= '0;
                        st  <= ref_phase ? SEQ_GAP : SEQ_IDLE;
                    end else begin
                        cnt <= cnt + CNTW'(1);
                    end
                end
                SEQ_GAP: begin
                    if (cnt == GAP_LAST) begin
                        cnt       <= '0;
                        st        <= SEQ_LAUNCH;
                        ref_phase <= 1'b0;
                    end else begin
                        cnt <= cnt + CNTW'(1);
                    end
                end
                default: begin
                    st  <= SEQ_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    // Reference repeat counter: held at zero while calibration is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !cal_en) begin
            cal_cnt <= '0;
        end else if (accept) begin
            cal_cnt <= (cal_cnt >= cal_div) ? '0 : cal_cnt + CAL_ONE;
        end
    end

    // Control decode from the registered phase.
    always_comb begin
        pulse_launch = (st == SEQ_LAUNCH);
        line_clear   = (st != SEQ_LAUNCH);
        tap_sample   = (st == SEQ_LAUNCH) && (cnt == CONV_LAST);
        ref_select   = (st == SEQ_LAUNCH) && ref_phase;
        sub_mode     = sub_q;
    end

endmodule

// File: rtl/dlq_tap_encoder.sv
// Tap capture and encoder.
// Registers all taps on the sample edge. Counts the set taps through a
// prefix-sum chain and centres the count on NTAPS/2.
// Assumes NTAPS is even and below 2**ERRW.
module dlq_tap_encoder #(
    parameter int NTAPS = 8,
    parameter int ERRW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTAPS-1:0]       taps,
    input  logic                   tap_sample,
    input  logic                   ref_select,
    output logic signed [ERRW-1:0] code,
    output logic                   code_vld,
    output logic                   code_ref
);

    localparam logic signed [ERRW:0] MID = (ERRW+1)'(NTAPS / 2);

    logic [NTAPS-1:0] tap_q;
    logic [ERRW-1:0]  psum [NTAPS+1];
    logic signed [ERRW:0] wide;

    // Capture taps and tag the conversion kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q    <= '0;
            code_vld <= 1'b0;
            code_ref <= 1'b0;
        end else begin
            code_vld <= tap_sample;
            if (tap_sample) begin
                tap_q    <= taps;
                code_ref <= ref_select;
            end
        end
    end

    // Count of set taps, one adder stage per tap.
    assign psum[0] = '0;
    for (genvar g = 0; g < NTAPS; g++) begin : g_count
        assign psum[g+1] = psum[g] + {{(ERRW-1){1'b0}}, tap_q[g]};
    end

    // Centre the count so that half the line set reads as zero.
    always_comb begin
        wide = $signed({1'b0, psum[NTAPS]}) - MID;
        code = wide[ERRW-1:0];
    end

endmodule

// File: rtl/dlq_err_calc.sv
// Reference store, subtraction and clipping.
// Stores the code of a reference conversion. Emits the code of an input
// conversion, minus the stored code when calibration is active, clipped
// to +-NTAPS/2 and marked by a one-cycle valid.
module dlq_err_calc #(
    parameter int NTAPS = 8,
    parameter int ERRW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [ERRW-1:0] code,
    input  logic                   code_vld,
    input  logic                   code_ref,
    input  logic                   sub_mode,
    output logic signed [ERRW-1:0] err_out,
    output logic                   err_valid
);

    localparam logic signed [ERRW:0] LIM_P = (ERRW+1)'(NTAPS / 2);
    localparam logic signed [ERRW:0] LIM_N = -LIM_P;

    logic signed [ERRW-1:0] ref_q;
    logic signed [ERRW:0]   diff;
    logic signed [ERRW-1:0] sat;

    // Difference against the stored reference, then clip.
    always_comb begin
        if (sub_mode) begin
            diff = $signed({code[ERRW-1], code}) - $signed({ref_q[ERRW-1], ref_q});
        end else begin
            diff = $signed({code[ERRW-1], code});
        end
        if (diff > LIM_P) begin
            sat = LIM_P[ERRW-1:0];
        end else if (diff < LIM_N) begin
            sat = LIM_N[ERRW-1:0];
        end else begin
            sat = diff[ERRW-1:0];
        end
    end

    // Store reference codes; publish input results with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            err_out   <= '0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= code_vld && !code_ref;
            if (code_vld && code_ref) begin
                ref_q <= code;
            end
            if (code_vld && !code_ref) begin
                err_out <= sat;
            end
        end
    end

endmodule

// File: rtl/dlq_backend.sv
// Delay-line quantizer back end: top level.
// Joins the sequencer, the tap encoder and the error calculator.
// Assumes the analog line settles within GAP_CYC cycles of clearing and
// that taps are stable at the sample edge.
module dlq_backend #(
    parameter int NTAPS    = 8,
    parameter int CONV_CYC = 6,
    parameter int GAP_CYC  = 3,
    parameter int CALW     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                period_start,
    input  logic                                cal_en,
    input  logic [CALW-1:0]                     cal_div,
    input  logic [NTAPS-1:0]                    taps,
    output logic                                pulse_launch,
    output logic                                line_clear,
    output logic                                tap_sample,
    output logic                                ref_select,
    output logic signed [$clog2(NTAPS/2+1):0]   err_out,
    output logic                                err_valid
);

    localparam int ERRW = $clog2(NTAPS/2 + 1) + 1;

    logic                   sub_mode;
    logic signed [ERRW-1:0] code;
    logic                   code_vld;
    logic                   code_ref;

    dlq_sequencer #(
        .CONV_CYC (CONV_CYC),
        .GAP_CYC  (GAP_CYC),
        .CALW     (CALW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .cal_en       (cal_en),
        .cal_div      (cal_div),
        .pulse_launch (pulse_launch),
        .line_clear   (line_clear),
        .tap_sample   (tap_sample),
        .ref_select   (ref_select),
        .sub_mode     (sub_mode)
    );

    dlq_tap_encoder #(
        .NTAPS (NTAPS),
        .ERRW  (ERRW)
    ) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .taps       (taps),
        .tap_sample (tap_sample),
        .ref_select (ref_select),
        .code       (code),
        .code_vld   (code_vld),
        .code_ref   (code_ref)
    );

    dlq_err_calc #(
        .NTAPS (NTAPS),
        .ERRW  (ERRW)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .code      (code),
        .code_vld  (code_vld),
        .code_ref  (code_ref),
        .sub_mode  (sub_mode),
        .err_out   (err_out),
        .err_valid (err_valid)
    );

endmodule

// File: rtl/dlq_backend_chk.sv
// Port-level protocol checks for dlq_backend, attached by bind.
module dlq_backend_chk #(
    parameter int NTAPS = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                line_clear,
    input logic                                tap_sample,
    input logic                                ref_select,
    input logic signed [$clog2(NTAPS/2+1):0]   err_out,
    input logic                                err_valid
);

    localparam int ERRW = $clog2(NTAPS/2 + 1) + 1;
    localparam logic signed [ERRW-1:0] TOP = ERRW'(NTAPS / 2);
    localparam logic signed [ERRW-1:0] BOT = -TOP;

    // R7: the valid strobe never lasts two cycles.
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    // R7: an input sample yields a result two cycles later.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tap_sample, 2) && !$past(ref_select, 2)) |-> err_valid);

    // R7: no result appears without an input sample before it.
    a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> ($past(tap_sample, 2) && !$past(ref_select, 2)));

    // R9: the published error stays within the clip limits.
    a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_out <= TOP && err_out >= BOT));

    // R9: a reference sample is followed by a clear gap on the input supply.
    a_r9_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sample && ref_select) |=> (line_clear && !ref_select));

    // R4: after an input sample the line is cleared.
    a_r4_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sample && !ref_select) |=> line_clear);

endmodule

bind dlq_backend dlq_backend_chk #(.NTAPS(NTAPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_clear (line_clear),
    .tap_sample (tap_sample),
    .ref_select (ref_select),
    .err_out    (err_out),
    .err_valid  (err_valid)
);

// File: tb/tb_dlq_backend.sv
`timescale 1ns/1ps
module tb_dlq_backend;

    localparam int NT   = 8;
    localparam int CONV = 6;
    localparam int GAP  = 3;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_start = 1'b0;
    logic          cal_en = 1'b0;
    logic [CW-1:0] cal_div = '0;
    logic [NT-1:0] taps;
    logic          pulse_launch, line_clear, tap_sample, ref_select, err_valid;
    logic signed [3:0] err_out;

    logic [NT-1:0] ref_pat = '0;
    logic [NT-1:0] in_pat  = '0;

    int n_chk = 0;
    int n_fail = 0;
    int bcal = 0;
    int bref = 0;

    // Line model: supply mux selects which pattern the taps show.
    assign taps = ref_select ? ref_pat : in_pat;

    always #10 clk = ~clk;

    dlq_backend #(.NTAPS(NT), .CONV_CYC(CONV), .GAP_CYC(GAP), .CALW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .cal_en(cal_en), .cal_div(cal_div), .taps(taps),
        .pulse_launch(pulse_launch), .line_clear(line_clear),
        .tap_sample(tap_sample), .ref_select(ref_select),
        .err_out(err_out), .err_valid(err_valid)
    );

    function automatic int f_code(logic [NT-1:0] p);
        int c = 0;
        for (int i = 0; i < NT; i++) c += int'(p[i]);
        return c - NT/2;
    endfunction

    function automatic int f_sat(int v);
        if (v > NT/2) return NT/2;
        if (v < -NT/2) return -NT/2;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One period: strobe, follow the sequence, check result and timing.
    task automatic run_period(input logic [NT-1:0] ip, input logic [NT-1:0] rp,
                              input bit dbl, input string tag);
        bit refp;
        int exp_err, exp_lat, n;
        in_pat  = ip;
        ref_pat = rp;
        refp = cal_en && (bcal == 0);
        if (refp) bref = f_code(rp);
        exp_err = cal_en ? f_sat(f_code(ip) - bref) : f_code(ip);
        exp_lat = refp ? 2*CONV + GAP + 1 : CONV + 1;
        if (!cal_en) bcal = 0;
        else bcal = (bcal >= int'(cal_div)) ? 0 : bcal + 1;

        @(negedge clk) period_start = 1'b1;
        @(negedge clk) period_start = 1'b0;
        n = 0;
        chk(pulse_launch && !line_clear, "R2", int'(pulse_launch), 1);
        chk(ref_select == refp, refp ? "R9" : "R10", int'(ref_select), int'(refp));
        while (!err_valid && n < 400) begin
            @(negedge clk);
            n++;
            period_start = dbl && (n == 2 || (refp && n == CONV + 1));
            if (!refp && n == CONV - 1)
                chk(tap_sample == 1'b1, "R3", int'(tap_sample), 1);
            if (refp && n == CONV)
                chk(line_clear && !ref_select, "R9", int'(line_clear), 1);
        end
        period_start = 1'b0;
        chk(n == exp_lat, refp ? "R9" : "R7", n, exp_lat);
        chk(int'(err_out) == exp_err, tag, int'(err_out), exp_err);
        @(negedge clk);
        chk(!err_valid, "R7", int'(err_valid), 0);
        for (int k = 0; k < (dbl ? CONV + 3 : 2); k++) begin
            chk(line_clear && !pulse_launch, dbl ? "R2" : "R4", int'(pulse_launch), 0);
            @(negedge clk);
        end
    endtask

    function automatic logic [NT-1:0] rnd_pat();
        int k;
        if ($urandom_range(1, 0) == 0) begin
            k = $urandom_range(NT, 0);
            return NT'((9'd1 << k) - 9'd1);
        end
        return NT'($urandom);
    endfunction

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(line_clear && !pulse_launch && !tap_sample && !ref_select && !err_valid,
            "R1", int'(line_clear), 1);

        // R5 / R8 plain conversions
        cal_en = 1'b0;
        run_period(8'b0000_1111, 8'h00, 1'b0, "R5");
        run_period(8'hFF, 8'h00, 1'b0, "R5");
        run_period(8'h00, 8'hFF, 1'b0, "R5");
        run_period(8'h3F, 8'h00, 1'b1, "R8");
        // R6 bubbled patterns
        run_period(8'b1010_0101, 8'h00, 1'b0, "R6");
        run_period(8'b0100_0111, 8'h00, 1'b0, "R6");

        // R9 calibration every period, including clipping
        cal_en = 1'b1; cal_div = 4'd0;
        run_period(8'h0F, 8'h07, 1'b0, "R9");
        run_period(8'h00, 8'hFF, 1'b1, "R9");
        run_period(8'hFF, 8'h00, 1'b0, "R9");

        // R10 stored reference reused between reference periods
        cal_en = 1'b0;
        run_period(8'h1F, 8'h00, 1'b0, "R8");
        cal_en = 1'b1; cal_div = 4'd2;
        run_period(8'h0F, 8'h03, 1'b0, "R10");
        run_period(8'h0F, 8'hFF, 1'b0, "R10");
        run_period(8'h7F, 8'h00, 1'b0, "R10");
        run_period(8'h0F, 8'h3F, 1'b1, "R10");

        // Random mix
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(7, 0) == 0) cal_en = ~cal_en;
            if ($urandom_range(7, 0) == 0) cal_div = CW'($urandom_range(3, 0));
            run_period(rnd_pat(), rnd_pat(), ($urandom_range(5, 0) == 0),
                       cal_en ? "R10" : "R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule